// File: doc/BRIEF.md
# In-Order Visibility Transaction Sequencer

A load that runs ahead of unresolved older work may read a cache line into a private side buffer without touching the cache hierarchy. Once such a load holds its line and is safe to expose, the line must be fetched again through the normal coherent path. This block does that second fetch. It walks the side-buffer entries in program order, starting at the oldest one. Each eligible entry gets one of two re-load requests. A publish request brings the line into the local cache. A confirm request brings the line in as well and also checks that the bytes the load consumed are still current. Several requests may be outstanding at the same time, but they always start in program order.

When a confirm response comes back, the returned line is compared with the buffered line, but only on the bytes the load actually read (its byte mask). If they agree, or if the response is for a publish request, the entry is reported complete in that cycle. If they disagree, the load read stale data: the block reports a squash for that entry in the same cycle. It then drops every outstanding request for that entry and for all younger entries, so their later responses are ignored, and it resumes scanning at the squashed slot. The block also tells the retirement logic to hold the oldest entry while that entry is still waiting to be scanned or still has a re-load outstanding.

The load queue owns entry allocation, the per-entry state field and the head pointer. It is expected to set an entry's state to complete on the completion pulse, and to invalidate the squashed entry and every younger entry at the same clock edge as the squash pulse. The depth is a power of two. The head pointer carries one extra wrap bit and resets to zero.

Top module: `visibility_sequencer`

## Requirements
- R1: After reset, with no valid entries, `req_valid`, `done_valid`, `squash_valid` and `hold_retire` are all 0.
- R2: A request is raised only for an entry that is valid, has its line (`ent_filled`), is at its visibility point (`ent_vis`), and whose 2-bit state is 1 (publish) or 2 (confirm). `req_validate` is 1 for state 2 and 0 for state 1.
- R3: Requests start strictly in program order from the head. An entry that needs a request but is not yet eligible blocks all younger entries. An invalid slot or a fully scanned queue stalls the scan.
- R4: An entry whose state is 0 (plain) or 3 (complete) is passed over without a request, at one entry per cycle.
- R5: New requests keep being issued while older ones are still outstanding. No entry is issued twice while it is outstanding.
- R6: A response for an outstanding publish request raises `done_valid` with `done_idx` equal to the response index, in the same cycle.
- R7: A response for an outstanding confirm request whose line matches the buffered line on every byte whose mask bit is 1 raises `done_valid`. Differences in bytes whose mask bit is 0 are ignored.
- R8: A response for an outstanding confirm request that differs on at least one masked byte raises `squash_valid` with `squash_idx` equal to the response index in the same cycle. `done_valid` stays 0, and no request is raised in that cycle.
- R9: After a squash, responses for the squashed entry and for younger entries that were outstanding are ignored, and scanning resumes at the squashed slot.
- R10: `hold_retire` is 1 when the head entry is valid and either has not yet been scanned or has a re-load outstanding. Otherwise it is 0.
- R11: A response whose index has no outstanding request produces neither completion nor squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_ptr | input | IW+1 | Oldest load-queue slot, with wrap bit |
| ent_valid | input | N | Entry allocated |
| ent_filled | input | N | Entry's line has arrived in the side buffer |
| ent_vis | input | N | Entry has reached its visibility point |
| ent_state | input | 2N | Per-entry state: 0 plain, 1 publish, 2 confirm, 3 complete |
| ent_line | input | N*LB*8 | Buffered line per entry |
| ent_mask | input | N*LB | Bytes of the line the load read |
| req_valid | output | 1 | Re-load request present |
| req_ready | input | 1 | Memory side accepts request |
| req_idx | output | IW | Entry of the request |
| req_validate | output | 1 | 1 confirm, 0 publish |
| rsp_valid | input | 1 | Re-load response present |
| rsp_idx | input | IW | Entry of the response |
| rsp_line | input | LB*8 | Returned line |
| done_valid | output | 1 | Entry finished its re-load |
| done_idx | output | IW | Finished entry |
| squash_valid | output | 1 | Stale read detected |
| squash_idx | output | IW | Squashed entry |
| hold_retire | output | 1 | Head entry must not retire |

## Verification
The bench goes after the scan blocking on an older entry that is not yet eligible, while a younger entry is ready. A design that scanned out of order would issue the younger request early. It corrupts returned lines on masked and on unmasked bytes. A comparator that ignored the mask would squash good loads, and one that missed a masked byte would complete loads that read stale data. It sends responses for entries killed by an earlier squash, and for entries that never issued. A design that kept those requests alive would raise completions or squashes that do not belong to any live load. It also checks retirement holding cycle by cycle: a wrong hold lets the head entry retire before its re-load finishes, or stalls retirement for no reason.

// File: rtl/vseq_pkg.sv
// Shared types for the visibility sequencer.
// Assumes a 2-bit per-entry state supplied by the load queue.
package vseq_pkg;
    typedef enum logic [1:0] {
        ST_PLAIN    = 2'd0,
        ST_PUBLISH  = 2'd1,
        ST_CONFIRM  = 2'd2,
        ST_COMPLETE = 2'd3
    } ld_state_e;
endpackage

// File: rtl/vseq_line_cmp.sv
// Masked line comparator: reports a match when every byte whose mask bit is
// set agrees between the buffered line and the returned line.
// Assumes byte b occupies bits [8b+7:8b] of each line.
module vseq_line_cmp #(
    parameter int LINE_BYTES = 8
) (
    input  logic [LINE_BYTES*8-1:0] buf_line,
    input  logic [LINE_BYTES-1:0]   buf_mask,
    input  logic [LINE_BYTES*8-1:0] ret_line,
    output logic                    lines_match
);
    logic [LINE_BYTES-1:0] byte_diff;

    // One difference flag per byte lane, gated by the read mask.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        assign byte_diff[b] = buf_mask[b] && (buf_line[b*8 +: 8] != ret_line[b*8 +: 8]);
    end

    assign lines_match = ~|byte_diff;
endmodule

// File: rtl/vseq_order.sv
// Program-order scan pointer. Advances one slot per accepted step and
// rewinds to a squashed slot. Also produces the mask of slots at or younger
// than the rewind slot. Assumes head_ptr resets to zero and never passes the
// scan pointer (the retirement hold guarantees this).
module vseq_order #(
    parameter int N_ENTRIES = 8,
    localparam int IW = $clog2(N_ENTRIES),
    localparam int PW = IW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        head_ptr,
    input  logic                 advance,
    input  logic                 rewind_en,
    input  logic [IW-1:0]        rewind_idx,
    output logic [PW-1:0]        seq_ptr,
    output logic                 seq_full,
    output logic [N_ENTRIES-1:0] younger_mask
);
    logic [IW-1:0] head_idx;
    logic [IW-1:0] rw_age;

    assign head_idx = head_ptr[IW-1:0];
    assign rw_age   = rewind_idx - head_idx;
    assign seq_full = (seq_ptr - head_ptr) == PW'(N_ENTRIES);

    // Per-slot age compare against the rewind slot.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_age
        assign younger_mask[g] = (IW'(g) - head_idx) >= rw_age;
    end

    // Scan pointer update: rewind has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seq_ptr <= '0;
        else if (rewind_en)
            seq_ptr <= head_ptr + {1'b0, rw_age};
        else if (advance)
            seq_ptr <= seq_ptr + PW'(1);
    end

    // R3: the scan never runs more than one full queue ahead of the head.
    assert_scan_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(seq_ptr - head_ptr) <= PW'(N_ENTRIES)));

    // R9: after a rewind the scan sits on the squashed slot.
    assert_rewind_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_en |=> (seq_ptr[IW-1:0] == $past(rewind_idx)));
endmodule

// File: rtl/vseq_track.sv
// Outstanding-request tracker: one in-flight flag and one kind flag
// (1 = confirm) per entry. A flush clears the flags of a set of entries.
// Assumes at most one set and one clear per cycle.
module vseq_track #(
    parameter int N_ENTRIES = 8,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [IW-1:0]        set_idx,
    input  logic                 set_kind,
    input  logic                 clr_en,
    input  logic [IW-1:0]        clr_idx,
    input  logic                 flush_en,
    input  logic [N_ENTRIES-1:0] flush_mask,
    output logic [N_ENTRIES-1:0] inflight,
    output logic [N_ENTRIES-1:0] kind
);
    // Flag update per entry: flush, then completion, then new issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= '0;
            kind     <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (flush_en && flush_mask[i])
                    inflight[i] <= 1'b0;
                else if (clr_en && (clr_idx == IW'(i)))
                    inflight[i] <= 1'b0;
                else if (set_en && (set_idx == IW'(i))) begin
                    inflight[i] <= 1'b1;
                    kind[i]     <= set_kind;
                end
            end
        end
    end

    // R5: an entry is never issued again while its request is outstanding.
    assert_no_reissue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !inflight[set_idx]);
endmodule

// File: rtl/visibility_sequencer.sv
// Top of the visibility sequencer. Scans load-queue entries in program
// order and issues publish or confirm re-loads. Checks confirm responses
// under the byte mask and reports completion or squash. Assumes the load
// queue marks entries complete on done_valid and invalidates the squashed
// entry and all younger ones at the edge where squash_valid is high.
module visibility_sequencer
    import vseq_pkg::*;
#(
    parameter int N_ENTRIES  = 8,
    parameter int LINE_BYTES = 8,
    localparam int IW = $clog2(N_ENTRIES),
    localparam int PW = IW + 1,
    localparam int LW = LINE_BYTES * 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PW-1:0]                   head_ptr,
    input  logic [N_ENTRIES-1:0]            ent_valid,
    input  logic [N_ENTRIES-1:0]            ent_filled,
    input  logic [N_ENTRIES-1:0]            ent_vis,
    input  logic [2*N_ENTRIES-1:0]          ent_state,
    input  logic [N_ENTRIES*LW-1:0]         ent_line,
    input  logic [N_ENTRIES*LINE_BYTES-1:0] ent_mask,
    output logic                            req_valid,
    input  logic                            req_ready,
    output logic [IW-1:0]                   req_idx,
    output logic                            req_validate,
    input  logic                            rsp_valid,
    input  logic [IW-1:0]                   rsp_idx,
    input  logic [LW-1:0]                   rsp_line,
    output logic                            done_valid,
    output logic [IW-1:0]                   done_idx,
    output logic                            squash_valid,
    output logic [IW-1:0]                   squash_idx,
    output logic                            hold_retire
);
    logic [PW-1:0]        seq_ptr;
    logic                 seq_full;
    logic [N_ENTRIES-1:0] younger_mask;
    logic [N_ENTRIES-1:0] inflight;
    logic [N_ENTRIES-1:0] kind;
    logic [IW-1:0]        seq_idx;
    logic [IW-1:0]        head_idx;
    ld_state_e            cur_state;
    logic                 have_entry;
    logic                 needs_txn;
    logic                 rsp_hit;
    logic                 lines_match;
    logic                 fire;
    logic                 skip;

    assign seq_idx  = seq_ptr[IW-1:0];
    assign head_idx = head_ptr[IW-1:0];

    // State of the entry under the scan pointer.
    assign cur_state  = ld_state_e'(ent_state[{seq_idx, 1'b0} +: 2]);
    assign have_entry = !seq_full && ent_valid[seq_idx];
    assign needs_txn  = (cur_state == ST_PUBLISH) || (cur_state == ST_CONFIRM);

    // Response classification: live hit, then masked compare for confirms.
    assign rsp_hit      = rsp_valid && inflight[rsp_idx];
    assign squash_valid = rsp_hit && kind[rsp_idx] && !lines_match;
    assign squash_idx   = rsp_idx;
    assign done_valid   = rsp_hit && !squash_valid;
    assign done_idx     = rsp_idx;

    // Request side: only the scan-pointer entry may issue, never during a squash.
    assign req_valid    = have_entry && needs_txn && ent_filled[seq_idx]
                          && ent_vis[seq_idx] && !squash_valid;
    assign req_idx      = seq_idx;
    assign req_validate = (cur_state == ST_CONFIRM);
    assign fire         = req_valid && req_ready;
    assign skip         = have_entry && !needs_txn && !squash_valid;

    // Retirement hold: head not yet scanned, or head still outstanding.
    assign hold_retire = ent_valid[head_idx] && ((seq_ptr == head_ptr) || inflight[head_idx]);

    vseq_line_cmp #(.LINE_BYTES(LINE_BYTES)) u_cmp (
        .buf_line    (ent_line[int'(rsp_idx)*LW +: LW]),
        .buf_mask    (ent_mask[int'(rsp_idx)*LINE_BYTES +: LINE_BYTES]),
        .ret_line    (rsp_line),
        .lines_match (lines_match)
    );

    vseq_order #(.N_ENTRIES(N_ENTRIES)) u_order (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_ptr     (head_ptr),
        .advance      (fire || skip),
        .rewind_en    (squash_valid),
        .rewind_idx   (rsp_idx),
        .seq_ptr      (seq_ptr),
        .seq_full     (seq_full),
        .younger_mask (younger_mask)
    );

    vseq_track #(.N_ENTRIES(N_ENTRIES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (fire),
        .set_idx    (seq_idx),
        .set_kind   (req_validate),
        .clr_en     (done_valid),
        .clr_idx    (rsp_idx),
        .flush_en   (squash_valid),
        .flush_mask (younger_mask),
        .inflight   (inflight),
        .kind       (kind)
    );

    // R9: a squash leaves nothing outstanding for the squashed entry.
    assert_squash_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> !inflight[$past(squash_idx)]);

    // R6: a completed entry is no longer outstanding afterwards.
    assert_done_retires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !inflight[$past(done_idx)]);

    // R11: a response with no outstanding request has no effect.
    assert_stale_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !inflight[rsp_idx]) |-> (!done_valid && !squash_valid));

    // R10: an outstanding head entry is always held.
    assert_head_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid[head_idx] && inflight[head_idx]) |-> hold_retire);
endmodule

// File: tb/visibility_sequencer_tb_top.sv
// Bench: a load-queue model plus a memory responder, driven by seeded random
// choices and a directed ordering case. Outputs are checked every cycle.
module visibility_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int LB = 8;
    localparam int IW = $clog2(N);
    localparam int PW = IW + 1;
    localparam int LW = LB * 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [PW-1:0]     head_ptr;
    logic [N-1:0]      ent_valid, ent_filled, ent_vis;
    logic [2*N-1:0]    ent_state;
    logic [N*LW-1:0]   ent_line;
    logic [N*LB-1:0]   ent_mask;
    logic              req_valid, req_ready, req_validate;
    logic [IW-1:0]     req_idx;
    logic              rsp_valid;
    logic [IW-1:0]     rsp_idx;
    logic [LW-1:0]     rsp_line;
    logic              done_valid, squash_valid, hold_retire;
    logic [IW-1:0]     done_idx, squash_idx;

    always #(CLK_PERIOD/2) clk = ~clk;

    visibility_sequencer #(.N_ENTRIES(N), .LINE_BYTES(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr),
        .ent_valid(ent_valid), .ent_filled(ent_filled), .ent_vis(ent_vis),
        .ent_state(ent_state), .ent_line(ent_line), .ent_mask(ent_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
        .req_validate(req_validate), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
        .rsp_line(rsp_line), .done_valid(done_valid), .done_idx(done_idx),
        .squash_valid(squash_valid), .squash_idx(squash_idx), .hold_retire(hold_retire)
    );

    // Load-queue model and responder bookkeeping.
    bit             m_valid [N];
    bit             m_filled[N];
    bit             m_vis   [N];
    logic [1:0]     m_state [N];
    logic [LW-1:0]  m_line  [N];
    logic [LB-1:0]  m_mask  [N];
    bit             out_f   [N];
    bit             out_k   [N];
    bit             killed  [N];
    logic [PW-1:0]  m_head, m_tail, m_seq;

    int nchk = 0, nerr = 0;
    int n_sq = 0, n_done_exp = 0, n_done_val = 0, n_unmasked_ok = 0;
    int n_killed_rsp = 0, n_stale = 0, max_out = 0, n_skip = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int age_of(input int i);
        return (i - int'(m_head[IW-1:0])) & (N - 1);
    endfunction

    task automatic drive_model();
        for (int i = 0; i < N; i++) begin
            ent_valid[i]            = m_valid[i];
            ent_filled[i]           = m_filled[i];
            ent_vis[i]              = m_vis[i];
            ent_state[2*i +: 2]     = m_state[i];
            ent_line[i*LW +: LW]    = m_line[i];
            ent_mask[i*LB +: LB]    = m_mask[i];
        end
        head_ptr = m_head;
    endtask

    task automatic alloc(input logic [1:0] st, input bit fl, input bit vs);
        int t;
        t = int'(m_tail[IW-1:0]);
        m_valid[t] = 1; m_state[t] = st; m_filled[t] = fl; m_vis[t] = vs;
        m_line[t] = {$urandom, $urandom};
        m_mask[t] = LB'($urandom);
        if (m_mask[t] == '0) m_mask[t] = LB'(1);
        killed[t] = 0;
        m_tail = m_tail + PW'(1);
    endtask

    // One cycle, called at a falling edge: drive, check, advance the model.
    task automatic cycle_once(input bit rnd);
        int ri, p, hidx, sa, cnt;
        bit do_rsp, live, corrupt_masked, corrupt_unmasked;
        bit exp_sq, exp_done, exp_req, exp_skip, exp_hold, have, need, full;
        logic [LW-1:0] line;
        string tag;
        ri = 0; do_rsp = 0; corrupt_masked = 0; corrupt_unmasked = 0;
        line = '0;
        if (rnd) begin
            int r, st;
            r = $urandom % 4;
            st = $urandom % N;
            if (r == 0) begin
                for (int k = 0; k < N; k++)
                    if (!do_rsp && out_f[(st + k) % N]) begin do_rsp = 1; ri = (st + k) % N; end
            end else if (r == 1 && !out_f[st]) begin
                do_rsp = 1; ri = st;
            end
            if (do_rsp) begin
                int mode, bs;
                bit hit;
                line = m_line[ri];
                mode = $urandom % 3;
                bs = $urandom % LB;
                hit = 0;
                for (int k = 0; k < LB; k++) begin
                    int b;
                    b = (bs + k) % LB;
                    if (!hit && mode == 1 && m_mask[ri][b]) begin
                        hit = 1; corrupt_masked = 1; line[b*8 +: 8] = ~line[b*8 +: 8];
                    end else if (!hit && mode == 2 && !m_mask[ri][b]) begin
                        hit = 1; corrupt_unmasked = 1; line[b*8 +: 8] = ~line[b*8 +: 8];
                    end
                end
            end
            req_ready = ($urandom % 4) != 0;
        end else begin
            req_ready = 1'b1;
        end
        drive_model();
        rsp_valid = do_rsp;
        rsp_idx   = IW'(ri);
        rsp_line  = line;
        #1;
        // Expected outputs from the requirement rules.
        live     = do_rsp && out_f[ri];
        exp_sq   = live && out_k[ri] && corrupt_masked;
        exp_done = live && !exp_sq;
        p        = int'(m_seq[IW-1:0]);
        full     = PW'(m_seq - m_head) == PW'(N);
        have     = !full && m_valid[p];
        need     = (m_state[p] == 2'd1) || (m_state[p] == 2'd2);
        exp_req  = have && need && m_filled[p] && m_vis[p] && !exp_sq;
        exp_skip = have && !need && !exp_sq;
        hidx     = int'(m_head[IW-1:0]);
        exp_hold = m_valid[hidx] && ((m_seq == m_head) || out_f[hidx]);

        tag = (have && !need) ? "R4 plain or complete entry passed over" : "R3 in-order request";
        chk(req_valid == exp_req, tag, 64'(req_valid), 64'(exp_req));
        if (exp_req && req_valid) begin
            chk(req_idx == IW'(p), "R3 request index", 64'(req_idx), 64'(p));
            chk(req_validate == (m_state[p] == 2'd2), "R2 request kind", 64'(req_validate), 64'(m_state[p] == 2'd2));
        end
        if (do_rsp && !out_f[ri]) tag = killed[ri] ? "R9 response after squash" : "R11 stale response";
        else tag = (do_rsp && out_k[ri]) ? "R7 confirm completion" : "R6 publish completion";
        chk(done_valid == exp_done, tag, 64'(done_valid), 64'(exp_done));
        if (exp_done && done_valid) chk(done_idx == IW'(ri), "R6 done index", 64'(done_idx), 64'(ri));
        chk(squash_valid == exp_sq, (do_rsp && !out_f[ri]) ? "R9 squash on dead entry" : "R8 squash",
            64'(squash_valid), 64'(exp_sq));
        if (exp_sq && squash_valid) chk(squash_idx == IW'(ri), "R8 squash index", 64'(squash_idx), 64'(ri));
        chk(hold_retire == exp_hold, "R10 retire hold", 64'(hold_retire), 64'(exp_hold));

        // Coverage bookkeeping.
        if (exp_sq) n_sq++;
        if (exp_done && out_k[ri]) n_done_val++;
        if (exp_done && !out_k[ri]) n_done_exp++;
        if (exp_done && out_k[ri] && corrupt_unmasked) n_unmasked_ok++;
        if (do_rsp && !out_f[ri] && killed[ri]) n_killed_rsp++;
        if (do_rsp && !out_f[ri] && !killed[ri]) n_stale++;
        if (exp_skip) n_skip++;

        // Model update as of the coming rising edge.
        if (exp_done) begin out_f[ri] = 0; m_state[ri] = 2'd3; end
        if (exp_sq) begin
            sa = age_of(ri);
            for (int i = 0; i < N; i++)
                if (age_of(i) >= sa) begin
                    if (out_f[i]) killed[i] = 1;
                    out_f[i] = 0; m_valid[i] = 0;
                end
            m_tail = m_head + PW'(sa);
            m_seq  = m_head + PW'(sa);
        end else if (exp_req && req_ready) begin
            out_f[p] = 1; out_k[p] = (m_state[p] == 2'd2);
            m_seq = m_seq + PW'(1);
        end else if (exp_skip) begin
            m_seq = m_seq + PW'(1);
        end
        cnt = 0;
        for (int i = 0; i < N; i++) cnt += int'(out_f[i]);
        if (cnt > max_out) max_out = cnt;
        if (rnd) begin
            if (!exp_hold && m_valid[hidx] && ($urandom % 2 == 0)) begin
                m_valid[hidx] = 0;
                m_head = m_head + PW'(1);
            end
            if (PW'(m_tail - m_head) < PW'(N) && ($urandom % 2 == 0))
                alloc(2'($urandom % 3), 1'b0, 1'b0);
            for (int i = 0; i < N; i++)
                if (m_valid[i]) begin
                    if ($urandom % 4 == 0) m_filled[i] = 1;
                    if ($urandom % 4 == 0) m_vis[i] = 1;
                end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_filled[i] = 0; m_vis[i] = 0; m_state[i] = 0;
            m_line[i] = '0; m_mask[i] = '0; out_f[i] = 0; out_k[i] = 0; killed[i] = 0;
        end
        m_head = '0; m_tail = '0; m_seq = '0;
        rst_n = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_idx = '0; rsp_line = '0;
        drive_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet outputs after reset with an empty queue.
        chk(req_valid == 1'b0, "R1 reset req_valid", 64'(req_valid), 64'd0);
        chk(done_valid == 1'b0, "R1 reset done_valid", 64'(done_valid), 64'd0);
        chk(squash_valid == 1'b0, "R1 reset squash_valid", 64'(squash_valid), 64'd0);
        chk(hold_retire == 1'b0, "R1 reset hold_retire", 64'(hold_retire), 64'd0);
        @(negedge clk);

        // Directed R3: oldest confirm entry lacks its line, younger publish is ready.
        alloc(2'd2, 1'b0, 1'b1);
        alloc(2'd1, 1'b1, 1'b1);
        drive_model();
        #1;
        chk(req_valid == 1'b0, "R3 older entry blocks younger", 64'(req_valid), 64'd0);
        @(negedge clk);
        cycle_once(1'b0);
        m_filled[0] = 1;
        cycle_once(1'b0);
        cycle_once(1'b0);
        cycle_once(1'b0);

        // Random phase.
        for (int c = 0; c < 5000; c++) cycle_once(1'b1);

        chk(max_out >= 2, "R5 overlapping requests seen", 64'(max_out), 64'd2);
        chk(n_sq > 0, "R8 squash exercised", 64'(n_sq), 64'd1);
        chk(n_done_val > 0, "R7 confirm completion exercised", 64'(n_done_val), 64'd1);
        chk(n_unmasked_ok > 0, "R7 unmasked difference ignored", 64'(n_unmasked_ok), 64'd1);
        chk(n_done_exp > 0, "R6 publish completion exercised", 64'(n_done_exp), 64'd1);
        chk(n_killed_rsp > 0, "R9 squashed response exercised", 64'(n_killed_rsp), 64'd1);
        chk(n_stale > 0, "R11 stale response exercised", 64'(n_stale), 64'd1);
        chk(n_skip > 0, "R4 skip exercised", 64'(n_skip), 64'd1);
        finish_run();
    end
endmodule